// File: doc/BRIEF.md
# Flash Mode Register Command Decoder

This block sits on the device side of a synchronous flash interface. On each rising clock it samples chip select, clock enable and three active-low strobes (row, column and mode). From these it decodes row activation, column access, row close and mode-register programming. Row and column addresses share one address bus. A row command captures the row half of the address, and a later column command captures the column half.

The block holds an 8-bit operating-mode register. It comes out of reset with a fixed non-zero setting. A legal programming command loads the register from the low address byte and starts a programming window of three clocks. During that window the block reports busy and accepts no command. A command that arrives inside the window makes the block enter a sticky illegal state. So does a programming command while a row is open. In that state the block ignores every further command until reset. The decoded mode fields go out as plain values that the burst and array logic use.

Top module: `fmr_cmd_decoder`

## Requirements
- R1: While `rst` is high at a clock edge, the block loads its defaults. These are burst length 4, sequential burst, column latency 5, row latency 2, array read, addresses 0, no open row, busy low and error low.
- R2: A programming command loads the mode register from address bits 7..0 at that edge. This happens when `cke` is high, `cs_n`, `ras_n`, `cas_n` and `mr_n` are all low, the block is not busy, no row is open and the error flag is low. The bit fields are:
  - Bits 1..0 give the burst length, decoded as 00→1, 01→2, 10→4 and 11→8.
  - Bit 2 gives the burst type, 0 sequential and 1 interleaved.
  - Bits 5..3 give the column latency code, which appears unchanged on `col_lat`.
  - Bit 6 gives the row latency, 0→1 and 1→2.
  - Bit 7 gives the read mode, 0 array and 1 identifier.
- R3: After an accepted programming command, `busy` is high for exactly three clock cycles and then low.
- R4: Any command (`cs_n` low, `cke` high, strobes not all high) sampled while `busy` is high sets the error flag. The command takes no effect.
- R5: A programming command sampled while a row is open sets the error flag and leaves the mode register unchanged.
- R6: The error flag stays high until reset. While it is high, every command is ignored.
- R7: With `cke` low, every command is ignored, including programming.
- R8: Row activate (`ras_n` low, `cas_n` high, `mr_n` high) captures `addr` into `row_addr` and sets `row_open`.
- R9: Column command (`ras_n` high, `cas_n` low, `mr_n` high) captures `addr` into `col_addr` only while a row is open. Otherwise it is ignored.
- R10: Row close (`ras_n` high, `cas_n` high, `mr_n` low) clears `row_open`.
- R11: With `cs_n` high, no command is decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| mr_n | input | 1 | Mode strobe, active low |
| cke | input | 1 | Clock enable; low means power-down |
| addr | input | ADDR_W | Multiplexed row/column/mode address bus |
| burst_len | output | 4 | Burst length in beats (1, 2, 4, 8) |
| burst_ilv | output | 1 | 1 = interleaved burst order |
| col_lat | output | 3 | Column latency code |
| row_lat | output | 2 | Row latency in cycles (1 or 2) |
| read_id | output | 1 | 1 = identifier read, 0 = array read |
| row_addr | output | ADDR_W | Latched row address |
| col_addr | output | ADDR_W | Latched column address |
| row_open | output | 1 | A row is active |
| busy | output | 1 | Mode programming window in progress |
| err | output | 1 | Sticky illegal-state flag |

## Verification
The properties assume that the control pins are stable around the sampling edge. They also assume that the reset is held for at least one edge before any command, so the busy counter and the mode register start from their defaults. The bench changes every input on the falling edge, half a period away from the sampling edge. It starts each scenario with an explicit multi-cycle reset. This keeps the sticky error from one scenario out of the next. Only strobe combinations named in the requirements are driven.

// File: rtl/fmr_pkg.sv
package fmr_pkg;

    typedef enum logic [2:0] {
        CMD_NOP,
        CMD_MRS,
        CMD_ACT,
        CMD_COL,
        CMD_CLOSE,
        CMD_OTHER
    } cmd_t;

    // Field order matches address bits 7..0
    typedef struct packed {
        logic       read_id;
        logic       row_lat_sel;
        logic [2:0] col_lat;
        logic       burst_ilv;
        logic [1:0] bl_code;
    } mode_t;

    localparam logic [7:0] MODE_DEFAULT_BITS = 8'h6A;
    localparam mode_t      MODE_DEFAULT      = mode_t'(MODE_DEFAULT_BITS);

    function automatic logic [3:0] burst_len_of(input logic [1:0] code);
        return 4'(1) << code;
    endfunction

    function automatic logic [1:0] row_lat_of(input logic sel);
        return sel ? 2'd2 : 2'd1;
    endfunction

endpackage

// File: rtl/fmr_cmd_decode.sv
module fmr_cmd_decode
    import fmr_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic mr_n,
    input  logic cke,
    output cmd_t cmd
);

    always_comb begin
        if (!cke || cs_n) begin
            cmd = CMD_NOP;
        end else begin
            case ({ras_n, cas_n, mr_n})
                3'b000:  cmd = CMD_MRS;
                3'b011:  cmd = CMD_ACT;
                3'b101:  cmd = CMD_COL;
                3'b110:  cmd = CMD_CLOSE;
                3'b111:  cmd = CMD_NOP;
                default: cmd = CMD_OTHER;
            endcase
        end
    end

endmodule

// File: rtl/fmr_mode_reg.sv
module fmr_mode_reg
    import fmr_pkg::*;
#(
    parameter int PGM_CYCLES = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic [7:0] data,
    output mode_t      mode,
    output logic       busy
);

    localparam int CNT_W = $clog2(PGM_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PGM_CYCLES);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode  <= MODE_DEFAULT;
            cnt_q <= '0;
        end else if (load) begin
            mode  <= mode_t'(data);
            cnt_q <= CNT_LOAD;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy = (cnt_q != '0);

endmodule

// File: rtl/fmr_addr_latch.sv
module fmr_addr_latch #(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              act_en,
    input  logic              col_en,
    input  logic              close_en,
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] row_addr,
    output logic [ADDR_W-1:0] col_addr,
    output logic              row_open
);

    always_ff @(posedge clk) begin
        if (rst) begin
            row_addr <= '0;
            col_addr <= '0;
            row_open <= 1'b0;
        end else begin
            if (act_en) begin
                row_addr <= addr;
                row_open <= 1'b1;
            end
            if (col_en && row_open) begin
                col_addr <= addr;
            end
            if (close_en) begin
                row_open <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/fmr_cmd_decoder.sv
module fmr_cmd_decoder
    import fmr_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int PGM_CYCLES = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              mr_n,
    input  logic              cke,
    input  logic [ADDR_W-1:0] addr,
    output logic [3:0]        burst_len,
    output logic              burst_ilv,
    output logic [2:0]        col_lat,
    output logic [1:0]        row_lat,
    output logic              read_id,
    output logic [ADDR_W-1:0] row_addr,
    output logic [ADDR_W-1:0] col_addr,
    output logic              row_open,
    output logic              busy,
    output logic              err
);

    cmd_t  cmd;
    mode_t mode;
    logic  live, conflict, exec;

    fmr_cmd_decode u_dec (
        .cs_n (cs_n),
        .ras_n(ras_n),
        .cas_n(cas_n),
        .mr_n (mr_n),
        .cke  (cke),
        .cmd  (cmd)
    );

    // A command counts once decoded and while the block is healthy
    assign live     = (cmd != CMD_NOP) && !err;
    assign conflict = live && (busy || ((cmd == CMD_MRS) && row_open));
    assign exec     = live && !conflict;

    always_ff @(posedge clk) begin
        if (rst) begin
            err <= 1'b0;
        end else if (conflict) begin
            err <= 1'b1;
        end
    end

    fmr_mode_reg #(.PGM_CYCLES(PGM_CYCLES)) u_mode (
        .clk (clk),
        .rst (rst),
        .load(exec && (cmd == CMD_MRS)),
        .data(addr[7:0]),
        .mode(mode),
        .busy(busy)
    );

    fmr_addr_latch #(.ADDR_W(ADDR_W)) u_addr (
        .clk     (clk),
        .rst     (rst),
        .act_en  (exec && (cmd == CMD_ACT)),
        .col_en  (exec && (cmd == CMD_COL)),
        .close_en(exec && (cmd == CMD_CLOSE)),
        .addr    (addr),
        .row_addr(row_addr),
        .col_addr(col_addr),
        .row_open(row_open)
    );

    assign burst_len = burst_len_of(mode.bl_code);
    assign burst_ilv = mode.burst_ilv;
    assign col_lat   = mode.col_lat;
    assign row_lat   = row_lat_of(mode.row_lat_sel);
    assign read_id   = mode.read_id;

endmodule

// File: rtl/fmr_checker.sv
module fmr_checker #(
    parameter int ADDR_W     = 12,
    parameter int PGM_CYCLES = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              mr_n,
    input logic              cke,
    input logic [ADDR_W-1:0] addr,
    input logic [3:0]        burst_len,
    input logic              burst_ilv,
    input logic [2:0]        col_lat,
    input logic [1:0]        row_lat,
    input logic              read_id,
    input logic [ADDR_W-1:0] row_addr,
    input logic [ADDR_W-1:0] col_addr,
    input logic              row_open,
    input logic              busy,
    input logic              err
);

    localparam int RUN_W = $clog2(PGM_CYCLES + 2) + 1;

    logic             sel_cmd, is_mrs, any_cmd;
    logic [RUN_W-1:0] busy_run;

    assign sel_cmd = cke && !cs_n;
    assign is_mrs  = sel_cmd && !ras_n && !cas_n && !mr_n;
    assign any_cmd = sel_cmd && !(ras_n && cas_n && mr_n);

    always_ff @(posedge clk) begin
        if (rst)       busy_run <= '0;
        else if (busy) busy_run <= busy_run + 1'b1;
        else           busy_run <= '0;
    end

    p_mrs_loads_r2: assert property (@(posedge clk) disable iff (rst)
        (is_mrs && !busy && !row_open && !err) |=>
            (col_lat == $past(addr[5:3])) && (burst_ilv == $past(addr[2])) && busy);

    p_busy_window_r3: assert property (@(posedge clk) disable iff (rst)
        busy_run <= RUN_W'(PGM_CYCLES));

    p_cmd_in_busy_r4: assert property (@(posedge clk) disable iff (rst)
        (busy && any_cmd) |=> err);

    p_mrs_open_r5: assert property (@(posedge clk) disable iff (rst)
        (is_mrs && row_open) |=> (err && $stable(col_lat) && $stable(burst_len)));

    p_err_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        err |=> (err && $stable(row_addr) && $stable(col_addr) && $stable(col_lat)));

    p_pwrdn_r7: assert property (@(posedge clk) disable iff (rst)
        !cke |=> ($stable(row_addr) && $stable(col_addr) && $stable(row_open)
                  && $stable(col_lat) && $stable(burst_len) && $stable(read_id)));

    p_col_gate_r9: assert property (@(posedge clk) disable iff (rst)
        !row_open |=> $stable(col_addr));

endmodule

bind fmr_cmd_decoder fmr_checker #(.ADDR_W(ADDR_W), .PGM_CYCLES(PGM_CYCLES)) u_chk (.*);

// File: tb/fmr_cmd_decoder_tb.sv
module fmr_cmd_decoder_tb;

    localparam int ADDR_W = 12;
    localparam int SNAP_W = 4 + 1 + 3 + 2 + 1 + 2 * ADDR_W + 3;

    logic clk = 1'b0;
    logic rst, cs_n, ras_n, cas_n, mr_n, cke;
    logic [ADDR_W-1:0] addr;
    logic [3:0] burst_len;
    logic burst_ilv, read_id, row_open, busy, err;
    logic [2:0] col_lat;
    logic [1:0] row_lat;
    logic [ADDR_W-1:0] row_addr, col_addr;

    always #4 clk = ~clk;   // 125 MHz

    fmr_cmd_decoder #(.ADDR_W(ADDR_W), .PGM_CYCLES(3)) u_dut (.*);

    typedef struct {
        logic [SNAP_W-1:0] snap;
        string             tag;
    } item_t;

    item_t q[$];
    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // Reference state, written from the requirements
    logic [7:0]        m_mode;
    int                m_cnt;
    logic              m_open, m_err;
    logic [ADDR_W-1:0] m_row, m_col;

    function automatic logic [SNAP_W-1:0] model_snap();
        return {4'(1) << m_mode[1:0], m_mode[2], m_mode[5:3],
                (m_mode[6] ? 2'd2 : 2'd1), m_mode[7],
                m_row, m_col, m_open, (m_cnt > 0), m_err};
    endfunction

    function automatic logic [SNAP_W-1:0] dut_snap();
        return {burst_len, burst_ilv, col_lat, row_lat, read_id,
                row_addr, col_addr, row_open, busy, err};
    endfunction

    task automatic model_step(input logic r, input logic c, input logic ra,
                              input logic ca, input logic m, input logic ck,
                              input logic [ADDR_W-1:0] a);
        bit live, conflict, ex, is_mrs;
        if (r) begin
            m_mode = 8'h6A; m_cnt = 0; m_open = 0; m_err = 0;
            m_row = '0; m_col = '0;
            return;
        end
        is_mrs   = ({ra, ca, m} == 3'b000);
        live     = ck && !c && ({ra, ca, m} != 3'b111) && !m_err;
        conflict = live && (m_cnt > 0 || (is_mrs && m_open));
        ex       = live && !conflict;
        if (conflict) m_err = 1;
        if (ex && {ra, ca, m} == 3'b011) begin m_row = a; m_open = 1; end
        if (ex && {ra, ca, m} == 3'b101 && m_open) m_col = a;
        if (ex && {ra, ca, m} == 3'b110) m_open = 0;
        if (ex && is_mrs) begin m_mode = a[7:0]; m_cnt = 3; end
        else if (m_cnt > 0) m_cnt--;
    endtask

    // Driver: applies one cycle of pins and queues the state expected after the edge
    task automatic drive(input logic r, input logic c, input logic ra,
                         input logic ca, input logic m, input logic ck,
                         input logic [ADDR_W-1:0] a, input string tag);
        item_t it;
        @(negedge clk);
        rst = r; cs_n = c; ras_n = ra; cas_n = ca; mr_n = m; cke = ck; addr = a;
        model_step(r, c, ra, ca, m, ck, a);
        it.snap = model_snap();
        it.tag  = tag;
        q.push_back(it);
    endtask

    task automatic do_reset();
        drive(1, 1, 1, 1, 1, 1, '0, "R1");
        drive(1, 1, 1, 1, 1, 1, '0, "R1");
    endtask
    task automatic nop(input string tag);
        drive(0, 0, 1, 1, 1, 1, '0, tag);
    endtask
    task automatic act(input logic [ADDR_W-1:0] a, input string tag);
        drive(0, 0, 0, 1, 1, 1, a, tag);
    endtask
    task automatic col(input logic [ADDR_W-1:0] a, input string tag);
        drive(0, 0, 1, 0, 1, 1, a, tag);
    endtask
    task automatic cls(input string tag);
        drive(0, 0, 1, 1, 0, 1, '0, tag);
    endtask
    task automatic mrs(input logic [7:0] v, input logic ck, input string tag);
        drive(0, 0, 0, 0, 0, ck, ADDR_W'(v), tag);
    endtask

    // Monitor: compares each queued expectation shortly after its edge
    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            item_t it;
            logic [SNAP_W-1:0] got;
            it  = q.pop_front();
            got = dut_snap();
            n_checks++;
            if (got !== it.snap) begin
                n_fail++;
                $display("FAIL %s: actual %h expected %h", it.tag, got, it.snap);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1; cs_n = 1; ras_n = 1; cas_n = 1; mr_n = 1; cke = 1; addr = '0;
        do_reset();
        nop("R1");
        drive(0, 1, 0, 0, 0, 1, 12'h0FF, "R11");   // deselected programming
        drive(0, 1, 0, 1, 1, 1, 12'h0AA, "R11");   // deselected activate
        act(12'h123, "R8");
        col(12'h045, "R9");
        cls("R10");
        act(12'h3AB, "R8");
        mrs(8'h9F, 1, "R5");                      // row open -> error
        nop("R6");
        act(12'h777, "R6");                       // ignored after error
        col(12'h001, "R6");

        do_reset();
        col(12'h055, "R9");                       // no open row -> ignored
        mrs(8'h9F, 1, "R2");                      // BL8, interleaved, CL3, RL1, ID
        nop("R3"); nop("R3"); nop("R3"); nop("R3");
        mrs(8'h01, 1, "R2");                      // BL2
        nop("R3");
        act(12'h200, "R4");                       // inside busy window
        nop("R4"); nop("R4");
        act(12'h201, "R6");

        do_reset();
        mrs(8'h00, 0, "R7");                      // power-down
        drive(0, 0, 0, 1, 1, 0, 12'h111, "R7");
        mrs(8'h00, 1, "R2");                      // BL1
        nop("R3"); nop("R3"); nop("R3");
        mrs(8'h3C, 1, "R2");                      // BL1, interleaved, CL7
        nop("R3"); nop("R3"); nop("R3");
        act(12'h0F0, "R8");
        mrs(8'h6A, 1, "R5");
        nop("R6");

        repeat (3) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule